// File: doc/BRIEF.md
# Receive Descriptor Ring Tracker

This block keeps the bookkeeping for one receive descriptor ring of a receive DMA engine. Each time the receive path finishes a frame it presents a completion event carrying the frame length and its start-of-packet, end-of-packet, CRC-error and overflow flags. When a descriptor is free, the block accepts the frame. It advances a 16-bit producer index, writes a status word for the descriptor at the current ring write address, and steps that address around the ring. When every descriptor is still owned by software, the frame is dropped and a 16-bit discard count is incremented instead.

Software returns descriptors by writing a 16-bit consumer index. Occupancy is the producer index minus the consumer index, modulo 65536. The block raises a flow-control pause output from two occupancy thresholds with hysteresis. It also pulses a done interrupt after a programmable number of accepted buffers. A read-only word reports the ring size together with the fixed buffer length.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset the producer index, discard count and consumer index are 0; pause and done are low; no descriptor write is signalled; the pause thresholds are XOFF_INIT and XON_INIT; the done threshold is DONE_INIT.
- R2: A frame event arriving while occupancy is below RING_ENTRIES (END_ENTRY−START_ENTRY) is accepted. The producer index then becomes (old+1) mod 65536 on the next cycle. `occupancy` always equals (producer − consumer) mod 65536.
- R3: A frame event arriving while occupancy is at least RING_ENTRIES is dropped. The producer index is unchanged, the discard count rises by one, and no descriptor write follows.
- R4: With SAT_DISCARD=1 the discard count saturates at 0xFFFF. Further drops leave it at 0xFFFF.
- R5: `prod_reg` reads discard count in bits [31:16] and producer index in bits [15:0]. A register write with select 0 loads both fields from the write data, so writing 0 clears the discard count. A frame event in the same cycle as that write is ignored.
- R6: One cycle after acceptance, `desc_we` pulses with `desc_status` = {length[31:16], 11'b0, fragmented[4], overflow[3], crc_error[2], eop[1], sop[0]}. Fragmented is set unless both SOP and EOP are set.
- R7: `desc_addr` starts at START_ENTRY*WORDS_PER_DESC and advances by WORDS_PER_DESC per accepted frame. After (END_ENTRY−1)*WORDS_PER_DESC it wraps back to the start. `end_addr` reads END_ENTRY*WORDS_PER_DESC−1.
- R8: The flow register (select 2) holds the pause-on threshold in [31:16] and the pause-off threshold in [15:0]. `xoff` becomes 1 one cycle after occupancy is at or above the pause-on threshold. It becomes 0 one cycle after occupancy is at or below the pause-off threshold. Between the two thresholds it holds its value.
- R9: The done threshold (select 3, bits [15:0]) sets how many accepted frames raise a one-cycle `done_irq`, issued in the same cycle as the descriptor write. Writing the threshold restarts the count. A threshold of 0 never raises the interrupt.
- R10: `bufsize_reg` reads RING_ENTRIES in [31:16] and BUF_LEN (2048) in [15:0].
- R11: A register write with select 1 sets the consumer index from bits [15:0]. Occupancy follows it on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frm_valid | input | 1 | Frame completion event |
| frm_len | input | 16 | Frame length in bytes |
| frm_sop | input | 1 | Start-of-packet flag |
| frm_eop | input | 1 | End-of-packet flag |
| frm_crc_err | input | 1 | CRC error flag |
| frm_ovf | input | 1 | Overflow flag |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 producer, 1 consumer, 2 flow, 3 done threshold |
| reg_wdata | input | 32 | Register write data |
| prod_reg | output | 32 | Discard count and producer index |
| cons_idx | output | 16 | Consumer index |
| occupancy | output | 16 | Descriptors held by software-visible ring |
| bufsize_reg | output | 32 | Ring size and buffer length |
| end_addr | output | 16 | Last word address of the ring |
| desc_we | output | 1 | Descriptor status write |
| desc_addr | output | 16 | Word address of the written descriptor |
| desc_status | output | 32 | Descriptor status word |
| xoff | output | 1 | Flow-control pause request |
| done_irq | output | 1 | Done interrupt pulse |

## Verification
Frames are sent with different flag mixes: complete, start-only, and CRC-flagged. These separate the fragment bit from the individual SOP, EOP and error bits in the status word. Enough frames are sent to wrap the write address, which distinguishes a correct wrap point from an off-by-one. Frames sent into a full ring, with the discard count preloaded just under its maximum, distinguish drop-and-count from overwrite and saturation from rollover. Consumer writes that land occupancy between, at and below the thresholds expose missing hysteresis. A producer preload of 0xFFFF checks modulo wrap of the index and occupancy. Done thresholds of 1, 3 and 0 separate per-buffer, counted and disabled interrupts.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   localparam int ST_SOP  = 0;
   localparam int ST_EOP  = 1;
   localparam int ST_CRC  = 2;
   localparam int ST_OVF  = 3;
   localparam int ST_FRAG = 4;

   localparam logic [1:0] SEL_PROD = 2'd0;
   localparam logic [1:0] SEL_CONS = 2'd1;
   localparam logic [1:0] SEL_FLOW = 2'd2;
   localparam logic [1:0] SEL_DONE = 2'd3;

   typedef struct packed {
      logic ovf;
      logic crc_err;
      logic eop;
      logic sop;
   } rx_flags_t;

   function automatic logic [15:0] pack_flags(input rx_flags_t f);
      logic [15:0] w;
      w          = '0;
      w[ST_SOP]  = f.sop;
      w[ST_EOP]  = f.eop;
      w[ST_CRC]  = f.crc_err;
      w[ST_OVF]  = f.ovf;
      w[ST_FRAG] = !(f.sop && f.eop);
      return w;
   endfunction
endpackage

// File: rtl/rxr_index_track.sv
module rxr_index_track #(
   parameter int IDX_W        = 16,
   parameter int RING_ENTRIES = 8,
   parameter bit SAT_DISCARD  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frm_valid,
   input  logic               prod_we,
   input  logic [2*IDX_W-1:0] prod_wdata,
   input  logic               cons_we,
   input  logic [IDX_W-1:0]   cons_wdata,
   output logic [IDX_W-1:0]   prod,
   output logic [IDX_W-1:0]   cons,
   output logic [IDX_W-1:0]   discard,
   output logic [IDX_W-1:0]   occ,
   output logic               accept
);
   localparam logic [IDX_W-1:0] RING_N  = IDX_W'(RING_ENTRIES);
   localparam logic [IDX_W-1:0] DISC_MX = '1;

   logic             full;
   logic             drop;
   logic [IDX_W-1:0] disc_inc;

   assign occ    = prod - cons;
   assign full   = (occ >= RING_N);
   assign accept = frm_valid && !full && !prod_we;
   assign drop   = frm_valid && full && !prod_we;

   generate
      if (SAT_DISCARD) begin : g_sat
         assign disc_inc = (discard == DISC_MX) ? discard : discard + 1'b1;
      end else begin : g_wrap
         assign disc_inc = discard + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod    <= '0;
         discard <= '0;
      end else if (prod_we) begin
         prod    <= prod_wdata[IDX_W-1:0];
         discard <= prod_wdata[2*IDX_W-1:IDX_W];
      end else begin
         if (accept) prod    <= prod + 1'b1;
         if (drop)   discard <= disc_inc;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cons <= '0;
      else if (cons_we) cons <= cons_wdata;
   end
endmodule

// File: rtl/rxr_desc_writer.sv
module rxr_desc_writer
   import rxr_pkg::*;
#(
   parameter int ADDR_W         = 16,
   parameter int LEN_W          = 16,
   parameter int WORDS_PER_DESC = 3,
   parameter int START_ENTRY    = 0,
   parameter int END_ENTRY      = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                accept,
   input  logic [LEN_W-1:0]    frm_len,
   input  rx_flags_t           flags,
   output logic                desc_we,
   output logic [ADDR_W-1:0]   desc_addr,
   output logic [LEN_W+15:0]   desc_status
);
   localparam logic [ADDR_W-1:0] FIRST = ADDR_W'(START_ENTRY * WORDS_PER_DESC);
   localparam logic [ADDR_W-1:0] LAST  = ADDR_W'((END_ENTRY - 1) * WORDS_PER_DESC);
   localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(WORDS_PER_DESC);

   logic [ADDR_W-1:0] wr_ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr      <= FIRST;
         desc_we     <= 1'b0;
         desc_addr   <= FIRST;
         desc_status <= '0;
      end else begin
         desc_we <= accept;
         if (accept) begin
            desc_addr   <= wr_ptr;
            desc_status <= {frm_len, pack_flags(flags)};
            wr_ptr      <= (wr_ptr == LAST) ? FIRST : wr_ptr + STEP;
         end
      end
   end
endmodule

// File: rtl/rxr_flow_ctl.sv
module rxr_flow_ctl #(
   parameter int IDX_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] occ,
   input  logic [IDX_W-1:0] on_thr,
   input  logic [IDX_W-1:0] off_thr,
   output logic             xoff
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                xoff <= 1'b0;
      else if (occ >= on_thr)    xoff <= 1'b1;
      else if (occ <= off_thr)   xoff <= 1'b0;
   end
endmodule

// File: rtl/rxr_done_irq.sv
module rxr_done_irq #(
   parameter int IDX_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             thr_we,
   input  logic [IDX_W-1:0] thr,
   output logic             irq
);
   logic [IDX_W-1:0] cnt;
   logic [IDX_W:0]   cnt_nx;
   logic             hit;

   assign cnt_nx = {1'b0, cnt} + 1'b1;
   assign hit    = (thr != '0) && (cnt_nx >= {1'b0, thr});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         irq <= 1'b0;
      end else if (thr_we) begin
         cnt <= '0;
         irq <= 1'b0;
      end else begin
         irq <= accept && hit;
         if (accept && thr != '0) cnt <= hit ? '0 : cnt_nx[IDX_W-1:0];
      end
   end
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
   import rxr_pkg::*;
#(
   parameter int IDX_W          = 16,
   parameter int ADDR_W         = 16,
   parameter int WORDS_PER_DESC = 3,
   parameter int START_ENTRY    = 0,
   parameter int END_ENTRY      = 8,
   parameter int BUF_LEN        = 2048,
   parameter int XOFF_INIT      = 6,
   parameter int XON_INIT       = 2,
   parameter int DONE_INIT      = 1,
   parameter bit SAT_DISCARD    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frm_valid,
   input  logic [IDX_W-1:0]     frm_len,
   input  logic                 frm_sop,
   input  logic                 frm_eop,
   input  logic                 frm_crc_err,
   input  logic                 frm_ovf,
   input  logic                 reg_we,
   input  logic [1:0]           reg_sel,
   input  logic [2*IDX_W-1:0]   reg_wdata,
   output logic [2*IDX_W-1:0]   prod_reg,
   output logic [IDX_W-1:0]     cons_idx,
   output logic [IDX_W-1:0]     occupancy,
   output logic [2*IDX_W-1:0]   bufsize_reg,
   output logic [ADDR_W-1:0]    end_addr,
   output logic                 desc_we,
   output logic [ADDR_W-1:0]    desc_addr,
   output logic [2*IDX_W-1:0]   desc_status,
   output logic                 xoff,
   output logic                 done_irq
);
   localparam int RING_ENTRIES = END_ENTRY - START_ENTRY;

   generate
      if (IDX_W != 16) begin : g_bad_idx
         $error("rx_desc_ring: index width must be 16");
      end
      if (RING_ENTRIES < 1) begin : g_bad_ring
         $error("rx_desc_ring: END_ENTRY must exceed START_ENTRY");
      end
      if (END_ENTRY * WORDS_PER_DESC > (1 << ADDR_W)) begin : g_bad_addr
         $error("rx_desc_ring: ring does not fit the address width");
      end
      if (WORDS_PER_DESC < 1) begin : g_bad_wpd
         $error("rx_desc_ring: descriptor must hold at least one word");
      end
   endgenerate

   logic             prod_we, cons_we, flow_we, done_we;
   logic [IDX_W-1:0] prod, discard, xoff_thr, xon_thr, done_thr;
   logic             accept;
   rx_flags_t        flags;

   assign prod_we = reg_we && (reg_sel == SEL_PROD);
   assign cons_we = reg_we && (reg_sel == SEL_CONS);
   assign flow_we = reg_we && (reg_sel == SEL_FLOW);
   assign done_we = reg_we && (reg_sel == SEL_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xoff_thr <= IDX_W'(XOFF_INIT);
         xon_thr  <= IDX_W'(XON_INIT);
         done_thr <= IDX_W'(DONE_INIT);
      end else begin
         if (flow_we) begin
            xoff_thr <= reg_wdata[2*IDX_W-1:IDX_W];
            xon_thr  <= reg_wdata[IDX_W-1:0];
         end
         if (done_we) done_thr <= reg_wdata[IDX_W-1:0];
      end
   end

   assign flags = '{ovf: frm_ovf, crc_err: frm_crc_err, eop: frm_eop, sop: frm_sop};

   rxr_index_track #(
      .IDX_W(IDX_W), .RING_ENTRIES(RING_ENTRIES), .SAT_DISCARD(SAT_DISCARD)
   ) u_idx (
      .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid),
      .prod_we(prod_we), .prod_wdata(reg_wdata),
      .cons_we(cons_we), .cons_wdata(reg_wdata[IDX_W-1:0]),
      .prod(prod), .cons(cons_idx), .discard(discard),
      .occ(occupancy), .accept(accept)
   );

   rxr_desc_writer #(
      .ADDR_W(ADDR_W), .LEN_W(IDX_W), .WORDS_PER_DESC(WORDS_PER_DESC),
      .START_ENTRY(START_ENTRY), .END_ENTRY(END_ENTRY)
   ) u_desc (
      .clk(clk), .rst_n(rst_n), .accept(accept), .frm_len(frm_len),
      .flags(flags), .desc_we(desc_we), .desc_addr(desc_addr),
      .desc_status(desc_status)
   );

   rxr_flow_ctl #(.IDX_W(IDX_W)) u_flow (
      .clk(clk), .rst_n(rst_n), .occ(occupancy),
      .on_thr(xoff_thr), .off_thr(xon_thr), .xoff(xoff)
   );

   rxr_done_irq #(.IDX_W(IDX_W)) u_done (
      .clk(clk), .rst_n(rst_n), .accept(accept),
      .thr_we(done_we), .thr(done_thr), .irq(done_irq)
   );

   assign prod_reg    = {discard, prod};
   assign bufsize_reg = {IDX_W'(RING_ENTRIES), IDX_W'(BUF_LEN)};
   assign end_addr    = ADDR_W'(END_ENTRY * WORDS_PER_DESC - 1);
endmodule

// File: rtl/rx_desc_ring_chk.sv
module rx_desc_ring_chk
   import rxr_pkg::*;
#(
   parameter int IDX_W        = 16,
   parameter int RING_ENTRIES = 8,
   parameter bit SAT_DISCARD  = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               frm_valid,
   input logic               reg_we,
   input logic [1:0]         reg_sel,
   input logic [2*IDX_W-1:0] prod_reg,
   input logic [IDX_W-1:0]   occupancy,
   input logic [IDX_W-1:0]   xoff_thr,
   input logic [IDX_W-1:0]   xon_thr,
   input logic               xoff,
   input logic               desc_we,
   input logic               done_irq
);
   localparam logic [IDX_W-1:0] RING_N = IDX_W'(RING_ENTRIES);
   logic pw;
   assign pw = reg_we && (reg_sel == SEL_PROD);

   a_r2_accept_advances: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && occupancy < RING_N && !pw) |=>
      (prod_reg[IDX_W-1:0] == IDX_W'($past(prod_reg[IDX_W-1:0]) + 1'b1)));

   a_r3_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && occupancy >= RING_N && !pw) |=>
      ($stable(prod_reg[IDX_W-1:0]) && !desc_we));

   generate
      if (SAT_DISCARD) begin : g_sat_chk
         a_r4_discard_saturates: assert property (@(posedge clk) disable iff (!rst_n)
            (prod_reg[2*IDX_W-1:IDX_W] == '1 && !pw) |=>
            (prod_reg[2*IDX_W-1:IDX_W] == '1));
      end
   endgenerate

   a_r6_desc_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
      desc_we |-> $past(frm_valid));

   a_r8_xoff_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xoff) |-> ($past(occupancy) >= $past(xoff_thr)));

   a_r8_xoff_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(xoff) |-> ($past(occupancy) <= $past(xon_thr)));

   a_r9_irq_with_desc: assert property (@(posedge clk) disable iff (!rst_n)
      done_irq |-> desc_we);
endmodule

bind rx_desc_ring rx_desc_ring_chk #(
   .IDX_W(IDX_W), .RING_ENTRIES(RING_ENTRIES), .SAT_DISCARD(SAT_DISCARD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .reg_we(reg_we),
   .reg_sel(reg_sel), .prod_reg(prod_reg), .occupancy(occupancy),
   .xoff_thr(xoff_thr), .xon_thr(xon_thr), .xoff(xoff),
   .desc_we(desc_we), .done_irq(done_irq)
);

// File: tb/rx_desc_ring_tb.sv
module rx_desc_ring_tb;
   localparam int RING = 8;
   localparam int WPD  = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frm_valid = 1'b0;
   logic [15:0] frm_len = '0;
   logic        frm_sop = 1'b0, frm_eop = 1'b0, frm_crc_err = 1'b0, frm_ovf = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_sel = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] prod_reg, bufsize_reg, desc_status;
   logic [15:0] cons_idx, occupancy, end_addr, desc_addr;
   logic        desc_we, xoff, done_irq;

   always #4 clk = ~clk;

   rx_desc_ring u_dut (
      .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_len(frm_len),
      .frm_sop(frm_sop), .frm_eop(frm_eop), .frm_crc_err(frm_crc_err),
      .frm_ovf(frm_ovf), .reg_we(reg_we), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .prod_reg(prod_reg), .cons_idx(cons_idx),
      .occupancy(occupancy), .bufsize_reg(bufsize_reg), .end_addr(end_addr),
      .desc_we(desc_we), .desc_addr(desc_addr), .desc_status(desc_status),
      .xoff(xoff), .done_irq(done_irq)
   );

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   logic [15:0] m_prod = 0, m_cons = 0, m_disc = 0, m_thr = 1, m_cnt = 0;
   int          m_slot = 0;
   logic [47:0] exp_q[$];

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard monitor: each descriptor write is matched to the oldest expected item
   always @(negedge clk) begin
      if (rst_n && desc_we) begin
         if (exp_q.size() == 0) check("R3 R6 unexpected descriptor", {16'h0, desc_addr}, 32'hFFFF_FFFF);
         else begin
            logic [47:0] e;
            e = exp_q.pop_front();
            check("R7 descriptor address", {16'h0, desc_addr}, {16'h0, e[47:32]});
            check("R6 descriptor status", desc_status, e[31:0]);
         end
      end
   end

   task automatic send_frame(input logic [15:0] len, input bit sop, input bit eop,
                             input bit crc, input bit ovf);
      bit acc, irq_exp;
      @(negedge clk);
      frm_valid = 1'b1; frm_len = len; frm_sop = sop; frm_eop = eop;
      frm_crc_err = crc; frm_ovf = ovf;
      acc = (16'(m_prod - m_cons) < RING);
      irq_exp = 1'b0;
      if (acc) begin
         exp_q.push_back({16'(m_slot * WPD),
                          len, 11'b0, !(sop && eop), ovf, crc, eop, sop});
         m_slot = (m_slot == RING - 1) ? 0 : m_slot + 1;
         m_prod = m_prod + 1;
         if (m_thr != 0) begin
            if (m_cnt + 1 >= m_thr) begin irq_exp = 1'b1; m_cnt = 0; end
            else m_cnt = m_cnt + 1;
         end
      end else if (m_disc != 16'hFFFF) m_disc = m_disc + 1;
      @(negedge clk);
      frm_valid = 1'b0;
      check(acc ? "R2 producer after accept" : "R3 R4 producer after drop",
            prod_reg, {m_disc, m_prod});
      check("R9 done interrupt", {31'b0, done_irq}, {31'b0, irq_exp});
      check("R2 occupancy", {16'h0, occupancy}, {16'h0, 16'(m_prod - m_cons)});
   endtask

   task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
      @(negedge clk);
      reg_we = 1'b0;
      case (sel)
         2'd0: begin m_prod = data[15:0]; m_disc = data[31:16]; end
         2'd1: m_cons = data[15:0];
         2'd3: begin m_thr = data[15:0]; m_cnt = 0; end
         default: ;
      endcase
   endtask

   task automatic check_xoff(input string req, input bit exp);
      @(negedge clk);
      check(req, {31'b0, xoff}, {31'b0, exp});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 producer register reset", prod_reg, 32'h0);
      check("R1 consumer reset", {16'h0, cons_idx}, 32'h0);
      check("R1 xoff reset", {31'b0, xoff}, 32'h0);
      check("R1 no descriptor write", {30'b0, desc_we, done_irq}, 32'h0);
      check("R10 buffer size word", bufsize_reg, {16'd8, 16'd2048});
      check("R7 end address", {16'h0, end_addr}, 32'd23);

      // threshold 1: interrupt per buffer, varied flag mixes
      send_frame(16'd64, 1, 1, 0, 0);
      send_frame(16'd100, 1, 0, 0, 0);
      send_frame(16'd1500, 1, 1, 1, 0);
      // threshold 3
      reg_write(2'd3, 32'd3);
      send_frame(16'd200, 0, 1, 0, 1);
      send_frame(16'd60, 1, 1, 0, 0);
      check_xoff("R8 xoff low below on threshold", 1'b0);
      send_frame(16'd61, 1, 1, 0, 0);      // occupancy 6
      check_xoff("R8 xoff at on threshold", 1'b1);
      send_frame(16'd62, 1, 1, 0, 0);
      send_frame(16'd63, 1, 1, 0, 0);      // occupancy 8, full
      send_frame(16'd64, 1, 1, 0, 0);      // dropped R3
      send_frame(16'd65, 1, 1, 0, 0);      // dropped R3
      check("R3 discard count after two drops", prod_reg, {16'd2, 16'd8});

      // consumer writes and hysteresis R11 R8
      reg_write(2'd1, 32'd4);
      check("R11 consumer index", {16'h0, cons_idx}, 32'd4);
      check("R11 occupancy after consumer write", {16'h0, occupancy}, 32'd4);
      check_xoff("R8 xoff held between thresholds", 1'b1);
      reg_write(2'd1, 32'd6);
      check_xoff("R8 xoff released at off threshold", 1'b0);
      reg_write(2'd1, 32'd7);

      // preload discard near max R5 R4, refill and wrap addresses R7
      reg_write(2'd0, {16'hFFFE, 16'd8});
      check("R5 producer register load", prod_reg, {16'hFFFE, 16'd8});
      for (int i = 0; i < 7; i++) send_frame(16'(300 + i), 1, 1, 0, 0);
      for (int i = 0; i < 3; i++) send_frame(16'd77, 1, 1, 0, 0);
      check("R4 discard saturated", prod_reg, {16'hFFFF, 16'd15});

      reg_write(2'd0, 32'h0);
      check("R5 write zero clears", prod_reg, 32'h0);

      // R5: frame in the same cycle as a producer write is ignored
      @(negedge clk);
      reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = {16'h0, 16'hFFFF}; frm_valid = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; frm_valid = 1'b0; m_prod = 16'hFFFF; m_disc = 0;
      check("R5 frame ignored during producer write", prod_reg, {16'h0, 16'hFFFF});
      check("R5 no descriptor during producer write", {31'b0, desc_we}, 32'h0);

      reg_write(2'd1, 32'h0000_FFFF);
      check_xoff("R8 xoff low at empty ring", 1'b0);
      send_frame(16'd128, 1, 1, 0, 0);     // producer wraps to 0
      check("R2 producer modulo wrap", prod_reg, 32'h0);
      check("R2 occupancy across wrap", {16'h0, occupancy}, 32'd1);

      // R9: threshold zero disables
      reg_write(2'd3, 32'd0);
      send_frame(16'd90, 1, 1, 0, 0);
      send_frame(16'd91, 1, 1, 0, 0);

      // R8: reprogram thresholds through the flow register
      reg_write(2'd2, {16'd2, 16'd1});
      check_xoff("R8 xoff with reprogrammed on threshold", 1'b1);

      repeat (3) @(negedge clk);
      check("R6 scoreboard drained", exp_q.size(), 32'd0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule